// File: doc/BRIEF.md
# Packed Vector Unpack Engine

This block carries out one unpack command at a time. A command supplies a shape code, a vector count and a 16-bit immediate. The engine then pulls 32-bit operand words from a FIFO and reads them as one continuous bitstream, starting at the least significant bit of the first word. It cuts the stream into packed vectors and spreads each vector over the four 32-bit columns of a 128-bit result. Each field can be sign-extended. One result per vector goes out on a local vector-memory write port, and consecutive vectors land in consecutive 16-byte slots.

Fields do not have to sit on word boundaries. A vector, or a single field, may start in one operand word and finish in the next. The engine keeps a bit buffer, so the words it reads add up to exactly the bits the command needs. A count register shows how many vectors are still to be written. A busy flag is high while a command is in progress. A command with a shape that has no defined meaning is refused with a one-cycle error pulse.

The parameter `ENGINE_ID` selects the instance variant. Only instance 1 honours the base-offset request in the immediate.

Top module: `vector_unpack_engine`

## Requirements
- R1: The shape code holds the vector length minus one (vn) in bits [3:2] and the width code (vl) in bits [1:0]. For vl = 0, 1, 2 each field is 32, 16 or 8 bits wide, and a vector takes width × (vn+1) bits.
- R2: Shape 4'b1111 selects a 16-bit vector made of three 5-bit fields at bit offsets 0, 5 and 10 and a 1-bit field at offset 15, for columns 0 to 3.
- R3: A shape with vl = 3 and vn ≠ 3 is refused. `cmd_err` is high for exactly the one cycle after `start`, `busy` stays low, and no operand word is taken and no write occurs.
- R4: Field j of vector k starts at bit k × (vector bits) + j × (field width) of the operand stream. Bit 0 is bit 0 of the first word, and bit 32 is bit 0 of the second word. A field that crosses a word boundary is assembled from both words.
- R5: When immediate bit 14 is set, every extracted field narrower than 32 bits is sign-extended, except the 1-bit field of shape 4'b1111. Otherwise fields are zero-extended.
- R6: Columns above vn are written as zero.
- R7: Vector k is written to slot address immediate[9:0] + k, plus the offset of R8, modulo 2^ADDR_W.
- R8: When immediate bit 15 is set, `base_offset` is added to the destination address, but only when ENGINE_ID = 1. With ENGINE_ID = 0 the bit is ignored.
- R9: `num_out` takes the count in the cycle after an accepted `start` and drops by one with each write. The command ends when it reaches zero. A count of 0 means 2^CNT_W vectors.
- R10: `busy` is high from the cycle after an accepted `start` until the cycle after the last write. A `start` raised while `busy` is high is ignored.
- R11: A command takes exactly ceil(count × vector bits / 32) operand words. `opw_ready` is high only while the engine is busy and its buffer holds less than one whole vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to start a command, sampled when idle |
| cmd_shape | input | 4 | Shape code: vn in [3:2], vl in [1:0] |
| cmd_count | input | CNT_W | Number of vectors (0 means 2^CNT_W) |
| cmd_imm | input | 16 | Address in [9:0], sign-extend enable in [14], offset enable in [15] |
| base_offset | input | ADDR_W | Offset added to the destination when enabled |
| opw_valid | input | 1 | Operand word is present |
| opw_data | input | 32 | Operand word |
| opw_ready | output | 1 | Engine takes the operand word this cycle |
| mem_we | output | 1 | Write strobe for one 128-bit result |
| mem_addr | output | ADDR_W | Destination slot address (16-byte units) |
| mem_data | output | 128 | Result vector, column 0 in bits [31:0] |
| num_out | output | CNT_W | Vectors still to be written |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | One-cycle pulse for a refused shape |

## Verification
The assertions assume three things about the inputs. `start` is raised only for one cycle at a time. The command fields are stable while `start` is high. `base_offset` and the operand words are free to change at any time, because the engine latches what it needs when it accepts a command. The stimulus drives commands for exactly one cycle. It feeds operand words with and without idle gaps, and it offers one word more than the command needs, so that an engine that reads too many words would be caught. To exercise the ignore rule, one run raises `start` in the middle of a busy command.

// File: rtl/vunpack_pkg.sv
package vunpack_pkg;

  localparam int COLS     = 4;
  localparam int ELEM_W   = 32;
  localparam int VECB_W   = 8;

  typedef struct packed {
    logic [1:0] vn;
    logic [1:0] vl;
  } shape_t;

  typedef struct packed {
    logic [5:0]        unit_w;
    logic [VECB_W-1:0] vec_w;
    logic              packed5;
    logic              legal;
  } geom_t;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_XFER = 1'b1
  } phase_t;

endpackage

// File: rtl/vunpack_decode.sv
module vunpack_decode
  import vunpack_pkg::*;
(
  input  shape_t shape,
  output geom_t  geom
);

  always_comb begin
    geom = '0;
    if (shape.vl != 2'd3) begin
      geom.unit_w  = 6'd32 >> shape.vl;
      geom.vec_w   = {2'b00, geom.unit_w} * ({6'b0, shape.vn} + 8'd1);
      geom.legal   = 1'b1;
    end else if (shape.vn == 2'd3) begin
      geom.unit_w  = 6'd5;
      geom.vec_w   = 8'd16;
      geom.packed5 = 1'b1;
      geom.legal   = 1'b1;
    end
  end

endmodule

// File: rtl/vunpack_bitbuf.sv
module vunpack_bitbuf #(
  parameter int WORD_W = 32,
  parameter int WIN_W  = 128,
  parameter int BUF_W  = WIN_W + WORD_W,
  parameter int FILL_W = $clog2(BUF_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              consume,
  input  logic [FILL_W-1:0] consume_w,
  output logic [WIN_W-1:0]  window,
  output logic [FILL_W-1:0] fill
);

  logic [BUF_W-1:0]  bits_q, bits_d;
  logic [FILL_W-1:0] fill_q, fill_d;
  logic [BUF_W-1:0]  word_ext;

  assign word_ext = {{(BUF_W-WORD_W){1'b0}}, word};

  always_comb begin
    bits_d = bits_q;
    fill_d = fill_q;
    if (clear) begin
      bits_d = '0;
      fill_d = '0;
    end else if (consume) begin
      bits_d = bits_q >> consume_w;
      fill_d = fill_q - consume_w;
    end else if (load) begin
      bits_d = bits_q | (word_ext << fill_q);
      fill_d = fill_q + FILL_W'(WORD_W);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      fill_q <= '0;
    end else if (clear || consume || load) begin
      bits_q <= bits_d;
      fill_q <= fill_d;
    end
  end

  assign window = bits_q[WIN_W-1:0];
  assign fill   = fill_q;

endmodule

// File: rtl/vunpack_extract.sv
module vunpack_extract
  import vunpack_pkg::*;
#(
  parameter int NCOL  = COLS,
  parameter int EW    = ELEM_W,
  parameter int WIN_W = NCOL * EW
) (
  input  logic [WIN_W-1:0]   window,
  input  geom_t              geom,
  input  logic [1:0]         vn,
  input  logic               sx_en,
  output logic [NCOL*EW-1:0] qw
);

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    logic [7:0]       off;
    logic [5:0]       w;
    logic [WIN_W-1:0] shifted;
    logic [EW-1:0]    mask;
    logic [EW-1:0]    col;
    logic             sign;

    always_comb begin
      w       = (geom.packed5 && c == NCOL-1) ? 6'd1 : geom.unit_w;
      off     = 8'(c) * {2'b00, geom.unit_w};
      shifted = window >> off;
      mask    = (w >= 6'(EW)) ? '1 : ((EW'(1) << w) - EW'(1));
      col     = shifted[EW-1:0] & mask;
      sign    = |(col & ~(mask >> 1));
      if (sx_en && w > 6'd1 && w < 6'(EW) && sign)
        col = col | ~mask;
      if (c > int'(vn))
        col = '0;
    end

    assign qw[c*EW +: EW] = col;
  end

endmodule

// File: rtl/vector_unpack_engine.sv
module vector_unpack_engine
  import vunpack_pkg::*;
#(
  parameter int ENGINE_ID = 1,
  parameter int ADDR_W    = 10,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [3:0]        cmd_shape,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic [15:0]       cmd_imm,
  input  logic [ADDR_W-1:0] base_offset,
  input  logic              opw_valid,
  input  logic [31:0]       opw_data,
  output logic              opw_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [127:0]      mem_data,
  output logic [CNT_W-1:0]  num_out,
  output logic              busy,
  output logic              cmd_err
);

  localparam int QW_W   = COLS * ELEM_W;
  localparam int BUF_W  = QW_W + ELEM_W;
  localparam int FILL_W = $clog2(BUF_W + 1);
  localparam int SX_BIT = 14;
  localparam int OF_BIT = 15;

  phase_t            phase_q, phase_d;
  shape_t            shape_q, shape_d;
  logic              sx_q, sx_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              err_q, err_d;

  shape_t            cmd_sh;
  geom_t             geom_cmd, geom_q;
  logic [FILL_W-1:0] fill;
  logic [QW_W-1:0]   window;
  logic [ADDR_W-1:0] ofs;
  logic              accept, have_vec, take_word;
  logic              unused_imm;

  assign cmd_sh     = shape_t'(cmd_shape);
  assign unused_imm = ^cmd_imm[SX_BIT-1:ADDR_W];

  vunpack_decode u_dec_cmd (.shape(cmd_sh),  .geom(geom_cmd));
  vunpack_decode u_dec_run (.shape(shape_q), .geom(geom_q));

  if (ENGINE_ID == 1) begin : g_ofs
    assign ofs = cmd_imm[OF_BIT] ? base_offset : '0;
  end else begin : g_no_ofs
    logic unused_ofs;
    assign unused_ofs = ^{base_offset, cmd_imm[OF_BIT]};
    assign ofs        = '0;
  end

  assign busy      = (phase_q == PH_XFER);
  assign have_vec  = busy && (fill >= FILL_W'(geom_q.vec_w));
  assign opw_ready = busy && !have_vec;
  assign take_word = opw_ready && opw_valid;
  assign accept    = start && !busy;

  vunpack_bitbuf #(
    .WORD_W(ELEM_W),
    .WIN_W (QW_W),
    .BUF_W (BUF_W),
    .FILL_W(FILL_W)
  ) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (accept),
    .load     (take_word),
    .word     (opw_data),
    .consume  (have_vec),
    .consume_w(FILL_W'(geom_q.vec_w)),
    .window   (window),
    .fill     (fill)
  );

  vunpack_extract #(
    .NCOL (COLS),
    .EW   (ELEM_W),
    .WIN_W(QW_W)
  ) u_ext (
    .window(window),
    .geom  (geom_q),
    .vn    (shape_q.vn),
    .sx_en (sx_q),
    .qw    (mem_data)
  );

  always_comb begin
    phase_d = phase_q;
    shape_d = shape_q;
    sx_d    = sx_q;
    rem_d   = rem_q;
    addr_d  = addr_q;
    err_d   = 1'b0;
    if (accept) begin
      if (geom_cmd.legal) begin
        phase_d = PH_XFER;
        shape_d = cmd_sh;
        sx_d    = cmd_imm[SX_BIT];
        rem_d   = cmd_count;
        addr_d  = cmd_imm[ADDR_W-1:0] + ofs;
      end else begin
        err_d   = 1'b1;
      end
    end else if (have_vec) begin
      rem_d  = rem_q - CNT_W'(1);
      addr_d = addr_q + ADDR_W'(1);
      if (rem_q == CNT_W'(1))
        phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      shape_q <= '0;
      sx_q    <= 1'b0;
      rem_q   <= '0;
      addr_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= err_d;
      if (accept || have_vec) begin
        phase_q <= phase_d;
        shape_q <= shape_d;
        sx_q    <= sx_d;
        rem_q   <= rem_d;
        addr_q  <= addr_d;
      end
    end
  end

  assign mem_we   = have_vec;
  assign mem_addr = addr_q;
  assign num_out  = rem_q;
  assign cmd_err  = err_q;

endmodule

// File: rtl/vunpack_checker.sv
module vunpack_checker #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [127:0]      mem_data,
  input logic [CNT_W-1:0]  num_out,
  input logic              opw_ready,
  input logic              cmd_err,
  input logic [1:0]        shape_vn
);

  AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy); // R10

  AST_IDLE_NO_PULL: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !opw_ready); // R11

  AST_NUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> num_out == CNT_W'($past(num_out) - 1'b1)); // R9

  AST_END_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> num_out == '0); // R9

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && num_out != CNT_W'(1)) |=>
      (!mem_we || mem_addr == ADDR_W'($past(mem_addr) + 1'b1))); // R7

  AST_REFUSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |-> !busy); // R3

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && shape_vn == 2'd0) |-> mem_data[127:32] == '0); // R6

endmodule

bind vector_unpack_engine vunpack_checker #(
  .ADDR_W(ADDR_W),
  .CNT_W (CNT_W)
) u_vunpack_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mem_we   (mem_we),
  .mem_addr (mem_addr),
  .mem_data (mem_data),
  .num_out  (num_out),
  .opw_ready(opw_ready),
  .cmd_err  (cmd_err),
  .shape_vn (shape_q.vn)
);

// File: tb/test_vector_unpack_engine.sv
module test_vector_unpack_engine;

  typedef struct packed {
    logic [3:0]  shape;
    logic [7:0]  count;
    logic [15:0] imm;
    logic [15:0] seed;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TABLE [NV] = '{
    '{4'b0000, 8'd3, 16'h0010, 16'd1},   // R1 scalar 32
    '{4'b1100, 8'd2, 16'h0100, 16'd2},   // R1 four x 32
    '{4'b0101, 8'd5, 16'h4020, 16'd3},   // R5 two x 16 signed
    '{4'b1001, 8'd3, 16'h0030, 16'd4},   // R4 three x 16 crossing words
    '{4'b1010, 8'd7, 16'h4005, 16'd5},   // R4 R5 three x 8 crossing
    '{4'b0010, 8'd9, 16'h0000, 16'd6},   // R6 scalar 8
    '{4'b1111, 8'd4, 16'h0200, 16'd7},   // R2 5/5/5/1
    '{4'b1111, 8'd5, 16'h4040, 16'd8},   // R2 R5 5/5/5/1 signed
    '{4'b0100, 8'd3, 16'h83FE, 16'd9},   // R7 R8 offset, wrap
    '{4'b1000, 8'd2, 16'h8100, 16'd10},  // R8 offset
    '{4'b0110, 8'd6, 16'h4000, 16'd11}   // R5 two x 8 signed
  };
  localparam logic [9:0] OFS = 10'h005;

  logic clk, rst_n, start, start0, opw_valid, opw_valid0;
  logic [3:0] cmd_shape;
  logic [7:0] cmd_count;
  logic [15:0] cmd_imm;
  logic [9:0] base_offset;
  logic [31:0] opw_data;
  logic opw_ready, mem_we, busy, cmd_err;
  logic [9:0] mem_addr;
  logic [127:0] mem_data;
  logic [7:0] num_out;
  logic opw_ready0, mem_we0, busy0, cmd_err0;
  logic [9:0] mem_addr0;
  logic [127:0] mem_data0;
  logic [7:0] num_out0;

  int total = 0, bad = 0, cycles = 0;
  logic [31:0] words [0:79];

  vector_unpack_engine #(.ENGINE_ID(1)) i_vector_unpack_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .cmd_shape(cmd_shape),
    .cmd_count(cmd_count), .cmd_imm(cmd_imm), .base_offset(base_offset),
    .opw_valid(opw_valid), .opw_data(opw_data), .opw_ready(opw_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .num_out(num_out), .busy(busy), .cmd_err(cmd_err));

  vector_unpack_engine #(.ENGINE_ID(0)) i_vector_unpack_engine_e0 (
    .clk(clk), .rst_n(rst_n), .start(start0), .cmd_shape(cmd_shape),
    .cmd_count(cmd_count), .cmd_imm(cmd_imm), .base_offset(base_offset),
    .opw_valid(opw_valid0), .opw_data(opw_data), .opw_ready(opw_ready0),
    .mem_we(mem_we0), .mem_addr(mem_addr0), .mem_data(mem_data0),
    .num_out(num_out0), .busy(busy0), .cmd_err(cmd_err0));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int vec_bits(input logic [3:0] sh);
    if (sh[1:0] == 2'd3) return 16;
    return (32 >> sh[1:0]) * (int'(sh[3:2]) + 1);
  endfunction

  function automatic logic [127:0] model_qw(input logic [3:0] sh,
                                            input logic [15:0] imm, input int k);
    logic [127:0] r;
    int vn, unit, vb, w, off;
    logic [31:0] f;
    r    = '0;
    vn   = int'(sh[3:2]);
    unit = (sh[1:0] == 2'd3) ? 5 : (32 >> sh[1:0]);
    vb   = vec_bits(sh);
    for (int i = 0; i <= vn; i++) begin
      w   = (sh[1:0] == 2'd3 && i == 3) ? 1 : unit;
      off = k * vb + i * unit;
      f   = '0;
      for (int b = 0; b < w; b++) f[b] = words[(off + b) / 32][(off + b) % 32];
      if (imm[14] && w > 1 && w < 32 && f[w-1])
        for (int b = w; b < 32; b++) f[b] = 1'b1;
      r[i*32 +: 32] = f;
    end
    return r;
  endfunction

  task automatic run_cmd(input vec_t v, input bit gaps, input bit poke, input string tag);
    int nvec, nwords, idx, k, cyc;
    bit take;
    logic [9:0] ea;
    for (int j = 0; j < 80; j++)
      words[j] = (32'(v.seed) * 32'h9E3779B9) ^ (32'(j) * 32'h7F4A7C15) ^ (32'(j) << 13);
    nvec   = (v.count == 0) ? 256 : int'(v.count);
    nwords = (nvec * vec_bits(v.shape) + 31) / 32;
    @(negedge clk);
    cmd_shape = v.shape; cmd_count = v.count; cmd_imm = v.imm; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R10 busy after start"}, 128'(busy), 128'd1);
    check(num_out === v.count, {tag, " R9 count loaded"}, 128'(num_out), 128'(v.count));
    idx = 0; k = 0; cyc = 0;
    while (k < nvec && cyc < 4000) begin
      if (poke && cyc == 2) begin
        cmd_shape = 4'b0000; cmd_count = 8'd1; cmd_imm = 16'h03FF; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      if (mem_we) begin
        ea = v.imm[9:0] + (v.imm[15] ? OFS : 10'd0) + 10'(k);
        check(mem_addr === ea, {tag, " R7 R8 address"}, 128'(mem_addr), 128'(ea));
        check(mem_data === model_qw(v.shape, v.imm, k),
              {tag, " R1 R2 R4 R5 R6 data"}, mem_data, model_qw(v.shape, v.imm, k));
        k++;
      end
      opw_valid = (idx <= nwords) && !(gaps && (cyc % 3 == 1));
      opw_data  = words[idx];
      take      = opw_valid && opw_ready;
      @(posedge clk);
      if (take) idx++;
      @(negedge clk);
      cyc++;
    end
    opw_valid = 1'b0;
    start     = 1'b0;
    check(k == nvec, {tag, " R9 vector count"}, 128'(k), 128'(nvec));
    check(busy === 1'b0 && mem_we === 1'b0, {tag, " R10 idle at end"},
          128'({busy, mem_we}), 128'd0);
    check(num_out === 8'd0, {tag, " R9 zero at end"}, 128'(num_out), 128'd0);
    check(idx == nwords, {tag, " R11 words taken"}, 128'(idx), 128'(nwords));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected=<150000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; start0 = 1'b0; opw_valid = 1'b0; opw_valid0 = 1'b0;
    cmd_shape = '0; cmd_count = '0; cmd_imm = '0; base_offset = OFS; opw_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(busy === 1'b0 && mem_we === 1'b0 && opw_ready === 1'b0 && cmd_err === 1'b0,
          "R10 R11 reset outputs", 128'({busy, mem_we, opw_ready, cmd_err}), 128'd0);
    check(num_out === 8'd0, "R9 reset count", 128'(num_out), 128'd0);

    for (int e = 0; e < NV; e++)
      run_cmd(TABLE[e], (e % 2) == 1, 1'b0, $sformatf("vec%0d", e));

    // R3: refused shape
    @(negedge clk);
    cmd_shape = 4'b0111; cmd_count = 8'd2; cmd_imm = 16'h0000;
    start = 1'b1; opw_valid = 1'b1; opw_data = 32'hDEADBEEF;
    @(negedge clk);
    start = 1'b0;
    check(cmd_err === 1'b1 && busy === 1'b0, "R3 error pulse", 128'({cmd_err, busy}), 128'b10);
    check(opw_ready === 1'b0, "R3 no word taken", 128'(opw_ready), 128'd0);
    @(negedge clk);
    check(cmd_err === 1'b0 && mem_we === 1'b0 && busy === 1'b0, "R3 pulse ends",
          128'({cmd_err, mem_we, busy}), 128'd0);
    opw_valid = 1'b0;

    // R10: start during a busy command is ignored
    run_cmd('{4'b1101, 8'd6, 16'h0080, 16'd12}, 1'b1, 1'b1, "poke");

    // R9: count zero means 256 vectors
    run_cmd('{4'b0010, 8'd0, 16'h0000, 16'd13}, 1'b0, 1'b0, "cnt0");

    // R8: offset request ignored on engine 0
    @(negedge clk);
    cmd_shape = 4'b0000; cmd_count = 8'd1; cmd_imm = 16'h8010; start0 = 1'b1;
    @(negedge clk);
    start0 = 1'b0; opw_valid0 = 1'b1; opw_data = 32'h12345678;
    @(negedge clk);
    opw_valid0 = 1'b0;
    check(mem_we0 === 1'b1 && mem_addr0 === 10'h010, "R8 engine0 no offset",
          128'({mem_we0, mem_addr0}), 128'({1'b1, 10'h010}));
    check(mem_data0 === 128'h12345678, "R6 engine0 data", mem_data0, 128'h12345678);
    @(negedge clk);
    check(busy0 === 1'b0, "R10 engine0 idle", 128'(busy0), 128'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule